// File: doc/BRIEF.md
# Diagnostic Pin Selector with Bypassable Divider Chain

This block produces the main divided clock and a diagnostic pin for a frequency synthesizer. A feedback counter divides its source by a programmable value M and marks each completed count with a pulse. A power-of-two post divider turns the same source into a square-wave main output. The normal source is the oscillator clock. A three-bit test code picks one of eight signals for the diagnostic pin. One code puts the chain in bypass: the slow serial configuration clock then drives both dividers, so a board can step the clock tree by hand.

All three incoming clocks (reference, serial, oscillator) are treated as slow signals. They are sampled by a fast system clock through a short synchronizer, and each rising edge becomes a one-cycle tick. Every divider advances only on ticks of its selected source. The diagnostic pin is registered on the system clock. In this text a "source period" is one rising edge of the selected source clock.

Top module: `testsel_divchain`

## Requirements
- R1: While reset is high, the main output and the diagnostic pin are low and all counters are cleared. The active M and N values are loaded from the inputs during reset.
- R2: The N code selects the main output division relative to the selected source: 00 divides by 2, 01 by 4, 10 by 8 and 11 by 16. The output has a 50% duty cycle and changes only on a source tick.
- R3: A new N code takes effect only when the current output period ends, at the falling edge of the main output. The half-period in progress completes with the old ratio.
- R4: The feedback counter raises its pulse on every M-th source tick. The pulse stays high for one source period. M of 0 or 1 keeps the pulse high. A new M takes effect at the next terminal count.
- R5: Test code 000 puts the serial data bit on the diagnostic pin, delayed by one system clock.
- R6: Test code 001 drives the pin to 1 and test code 101 drives it to 0.
- R7: Test code 010 puts the reference clock divided by 16 on the pin.
- R8: Test code 011 puts the feedback counter pulse on the pin.
- R9: Test code 100 puts the main output on the pin. Test code 111 puts the main output divided by 4 on the pin.
- R10: Test code 110 is bypass. The serial clock drives both dividers and the oscillator is ignored. The pin shows the feedback counter pulse. Under every other code the dividers ignore the serial clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_i | input | 1 | Reference clock, slow relative to clk |
| ser_clk_i | input | 1 | Serial configuration clock |
| osc_clk_i | input | 1 | Oscillator clock, the normal divider source |
| m_val_i | input | M_W | Feedback divide value |
| n_code_i | input | 2 | Post-divider code |
| t_sel_i | input | 3 | Diagnostic pin selection code |
| ser_dout_i | input | 1 | Serial shift register output bit |
| fout_o | output | 1 | Main divided output |
| test_o | output | 1 | Diagnostic pin |

## Verification
The hardest case to reach from the ports is a settings change that lands inside an output period. The reload must wait for the period boundary, and it shows up only as a changed spacing of edges several source periods later. The stimulus steps the source one period at a time and waits until the main output (or the feedback pulse) is seen high. Only then does it change N or M, and it counts source periods to the next edges: first the remainder of the old period, then a full period at the new ratio. Bypass is checked in both directions: an active oscillator under the bypass code must move nothing, and an active serial clock under a normal code must move nothing.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

    // Diagnostic pin selection codes
    typedef enum logic [2:0] {
        TS_SHIFT  = 3'b000,
        TS_ONE    = 3'b001,
        TS_REFDIV = 3'b010,
        TS_MCNT   = 3'b011,
        TS_FOUT   = 3'b100,
        TS_ZERO   = 3'b101,
        TS_BYPASS = 3'b110,
        TS_FOUTQ  = 3'b111
    } tsel_e;

    // Index of each sampled clock inside the tick vector
    localparam int SRC_OSC = 0;
    localparam int SRC_SER = 1;
    localparam int SRC_REF = 2;
    localparam int NUM_SRC = 3;

    localparam int NCODE_W = 2;
    localparam int HALF_W  = 4;

    // Source ticks per half output period for a given N code
    function automatic logic [HALF_W-1:0] half_ticks(input logic [NCODE_W-1:0] code);
        return HALF_W'(1) << code;
    endfunction

endpackage

// File: rtl/tsd_edge_tick.sv
module tsd_edge_tick #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic tick
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], din};
    end

    assign tick = sh[STAGES-1] & ~sh[STAGES];

endmodule

// File: rtl/tsd_fb_counter.sv
module tsd_fb_counter #(
    parameter int M_W = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic [M_W-1:0] m_i,
    output logic           pulse_o
);
    logic [M_W-1:0] m_act;
    logic [M_W-1:0] cnt;
    logic           term;

    assign term = ({1'b0, cnt} + 1'b1) >= {1'b0, m_act};

    always_ff @(posedge clk) begin
        if (rst) begin
            m_act   <= m_i;
            cnt     <= '0;
            pulse_o <= 1'b0;
        end else if (tick) begin
            if (term) begin
                cnt     <= '0;
                m_act   <= m_i;
                pulse_o <= 1'b1;
            end else begin
                cnt     <= cnt + 1'b1;
                pulse_o <= 1'b0;
            end
        end
    end

    AST_MPULSE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_o) |-> $past(tick)); // R4
    AST_MCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (m_act != '0) |-> (cnt < m_act)); // R4

endmodule

// File: rtl/tsd_post_div.sv
module tsd_post_div
    import tsd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [NCODE_W-1:0] n_i,
    output logic               fout_o,
    output logic               rise_o
);
    logic [NCODE_W-1:0] n_act;
    logic [HALF_W-1:0]  hcnt;
    logic               term;

    assign term = (hcnt + 1'b1) >= half_ticks(n_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            n_act  <= n_i;
            hcnt   <= '0;
            fout_o <= 1'b0;
            rise_o <= 1'b0;
        end else begin
            rise_o <= 1'b0;
            if (tick) begin
                if (term) begin
                    hcnt   <= '0;
                    fout_o <= ~fout_o;
                    rise_o <= ~fout_o;
                    if (fout_o) n_act <= n_i;
                end else begin
                    hcnt <= hcnt + 1'b1;
                end
            end
        end
    end

    AST_FOUT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(fout_o)); // R2
    AST_N_AT_PERIOD_END: assert property (@(posedge clk) disable iff (rst)
        !$stable(n_act) |-> $fell(fout_o)); // R3

endmodule

// File: rtl/tsd_pow2_div.sv
module tsd_pow2_div #(
    parameter int LOG2 = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic q_o
);
    logic [LOG2-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

    assign q_o = cnt[LOG2-1];

    AST_DIV_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(q_o)); // R7

endmodule

// File: rtl/testsel_divchain.sv
module testsel_divchain
    import tsd_pkg::*;
#(
    parameter int M_W         = 9,
    parameter int SYNC_STAGES = 2,
    parameter int REF_LOG2    = 4,
    parameter int FOUT_LOG2   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_clk_i,
    input  logic               ser_clk_i,
    input  logic               osc_clk_i,
    input  logic [M_W-1:0]     m_val_i,
    input  logic [NCODE_W-1:0] n_code_i,
    input  logic [2:0]         t_sel_i,
    input  logic               ser_dout_i,
    output logic               fout_o,
    output logic               test_o
);
    logic [NUM_SRC-1:0] clk_raw;
    logic [NUM_SRC-1:0] tick;
    tsel_e              mode;
    logic               bypass;
    logic               src_tick;
    logic               m_pulse;
    logic               fout_rise;
    logic               ref_div;
    logic               fout_div;
    logic               test_d;

    always_comb begin
        clk_raw          = '0;
        clk_raw[SRC_OSC] = osc_clk_i;
        clk_raw[SRC_SER] = ser_clk_i;
        clk_raw[SRC_REF] = ref_clk_i;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_tick
        tsd_edge_tick #(.STAGES(SYNC_STAGES)) u_tick (
            .clk  (clk),
            .rst  (rst),
            .din  (clk_raw[g]),
            .tick (tick[g])
        );
    end

    assign mode     = tsel_e'(t_sel_i);
    assign bypass   = (mode == TS_BYPASS);
    assign src_tick = bypass ? tick[SRC_SER] : tick[SRC_OSC];

    tsd_fb_counter #(.M_W(M_W)) u_fb (
        .clk     (clk),
        .rst     (rst),
        .tick    (src_tick),
        .m_i     (m_val_i),
        .pulse_o (m_pulse)
    );

    tsd_post_div u_post (
        .clk    (clk),
        .rst    (rst),
        .tick   (src_tick),
        .n_i    (n_code_i),
        .fout_o (fout_o),
        .rise_o (fout_rise)
    );

    tsd_pow2_div #(.LOG2(REF_LOG2)) u_refdiv (
        .clk  (clk),
        .rst  (rst),
        .tick (tick[SRC_REF]),
        .q_o  (ref_div)
    );

    tsd_pow2_div #(.LOG2(FOUT_LOG2)) u_foutdiv (
        .clk  (clk),
        .rst  (rst),
        .tick (fout_rise),
        .q_o  (fout_div)
    );

    always_comb begin
        case (mode)
            TS_SHIFT:  test_d = ser_dout_i;
            TS_ONE:    test_d = 1'b1;
            TS_REFDIV: test_d = ref_div;
            TS_MCNT:   test_d = m_pulse;
            TS_FOUT:   test_d = fout_o;
            TS_ZERO:   test_d = 1'b0;
            TS_BYPASS: test_d = m_pulse;
            TS_FOUTQ:  test_d = fout_div;
            default:   test_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) test_o <= 1'b0;
        else     test_o <= test_d;
    end

    AST_BYPASS_OSC_BLIND: assert property (@(posedge clk) disable iff (rst)
        (bypass && !tick[SRC_SER]) |=> $stable(fout_o)); // R10
    AST_NORMAL_SER_BLIND: assert property (@(posedge clk) disable iff (rst)
        (!bypass && !tick[SRC_OSC]) |=> $stable(fout_o)); // R10
    AST_CONST_HIGH: assert property (@(posedge clk) disable iff (rst)
        (mode == TS_ONE) |=> test_o); // R6
    AST_CONST_LOW: assert property (@(posedge clk) disable iff (rst)
        (mode == TS_ZERO) |=> !test_o); // R6

endmodule

// File: tb/sim_testsel_divchain.sv
`timescale 1ns/1ps
module sim_testsel_divchain;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       refc = 1'b0, serc = 1'b0, oscc = 1'b0, sdo = 1'b0;
    logic [8:0] m = 9'd5;
    logic [1:0] n = 2'd0;
    logic [2:0] t = 3'd4;
    logic       fout, test;

    always #4 clk = ~clk;

    testsel_divchain u0 (
        .clk(clk), .rst(rst), .ref_clk_i(refc), .ser_clk_i(serc), .osc_clk_i(oscc),
        .m_val_i(m), .n_code_i(n), .t_sel_i(t), .ser_dout_i(sdo),
        .fout_o(fout), .test_o(test)
    );

    int   checks = 0, fails = 0;
    int   fr = 0, tr = 0;
    bit   counting = 1'b0;
    logic pf = 1'b0, pt = 1'b0;

    always @(negedge clk) begin
        if (counting) begin
            if (fout && !pf) fr++;
            if (test && !pt) tr++;
        end
        pf = fout;
        pt = test;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // One source period: 4 system clocks high, 4 low. src bit0 osc, bit1 serial.
    task automatic one_period(input logic [1:0] src);
        @(negedge clk);
        oscc = src[0]; serc = src[1]; sdo = src[1]; refc = 1'b1;
        repeat (4) @(negedge clk);
        oscc = 1'b0; serc = 1'b0; sdo = 1'b0; refc = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; oscc = 0; serc = 0; sdo = 0; refc = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // {req(4), t(3), n(2), m(9), src(2), fout rises(16), test rises(16)} over 64 periods
    localparam int NV = 17;
    localparam logic [51:0] VEC [NV] = '{
        {4'd9,  3'd4, 2'd0, 9'd5, 2'b01, 16'd32, 16'd32}, // R9 fout on pin
        {4'd2,  3'd4, 2'd1, 9'd5, 2'b01, 16'd16, 16'd16}, // R2 div 4
        {4'd2,  3'd4, 2'd2, 9'd5, 2'b01, 16'd8,  16'd8},  // R2 div 8
        {4'd2,  3'd4, 2'd3, 9'd5, 2'b01, 16'd4,  16'd4},  // R2 div 16
        {4'd8,  3'd3, 2'd0, 9'd5, 2'b01, 16'd32, 16'd12}, // R8 M pulse
        {4'd4,  3'd3, 2'd0, 9'd8, 2'b01, 16'd32, 16'd8},  // R4 M = 8
        {4'd7,  3'd2, 2'd1, 9'd5, 2'b01, 16'd16, 16'd4},  // R7 ref / 16
        {4'd9,  3'd7, 2'd0, 9'd5, 2'b01, 16'd32, 16'd8},  // R9 fout / 4
        {4'd9,  3'd7, 2'd1, 9'd5, 2'b01, 16'd16, 16'd4},  // R9 fout / 4
        {4'd6,  3'd1, 2'd0, 9'd5, 2'b01, 16'd32, 16'd1},  // R6 const 1
        {4'd6,  3'd5, 2'd0, 9'd5, 2'b01, 16'd32, 16'd0},  // R6 const 0
        {4'd5,  3'd0, 2'd0, 9'd5, 2'b11, 16'd32, 16'd64}, // R5 serial data
        {4'd10, 3'd6, 2'd1, 9'd4, 2'b10, 16'd16, 16'd16}, // R10 bypass from serial
        {4'd10, 3'd6, 2'd0, 9'd5, 2'b01, 16'd0,  16'd0},  // R10 osc ignored
        {4'd10, 3'd4, 2'd0, 9'd5, 2'b10, 16'd0,  16'd0},  // R10 serial ignored
        {4'd10, 3'd6, 2'd0, 9'd3, 2'b11, 16'd32, 16'd21}, // R10 both active
        {4'd4,  3'd3, 2'd0, 9'd1, 2'b01, 16'd32, 16'd1}   // R4 M = 1 stays high
    };

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
        report();
        $finish;
    end

    initial begin
        int cnt;
        // R1: outputs low while reset is held, even with constant-1 code
        t = 3'd1;
        repeat (4) @(negedge clk);
        check(fout == 1'b0, "R1 fout in reset", fout, 0);
        check(test == 1'b0, "R1 test in reset", test, 0);

        for (int i = 0; i < NV; i++) begin
            t = VEC[i][47:45]; n = VEC[i][44:43]; m = VEC[i][42:34];
            do_reset();
            fr = 0; tr = 0; counting = 1'b1;
            repeat (64) one_period(VEC[i][33:32]);
            repeat (8) @(negedge clk);
            counting = 1'b0;
            check(fr == int'(VEC[i][31:16]), $sformatf("R%0d row %0d fout", VEC[i][51:48], i),
                  fr, int'(VEC[i][31:16]));
            check(tr == int'(VEC[i][15:0]), $sformatf("R%0d row %0d test", VEC[i][51:48], i),
                  tr, int'(VEC[i][15:0]));
        end

        // R3: N change during the high half waits for the period end
        t = 3'd4; n = 2'd0; m = 9'd5;
        do_reset();
        cnt = 0;
        do begin one_period(2'b01); cnt++; end while (!fout && cnt < 4);
        check(cnt == 1, "R3 first rise", cnt, 1);
        n = 2'd3;
        cnt = 0;
        do begin one_period(2'b01); cnt++; end while (fout && cnt < 20);
        check(cnt == 1, "R3 old half completes", cnt, 1);
        cnt = 0;
        do begin one_period(2'b01); cnt++; end while (!fout && cnt < 20);
        check(cnt == 8, "R3 new low half", cnt, 8);

        // R4: M change applies at the next terminal count
        t = 3'd3; m = 9'd5; n = 2'd0;
        do_reset();
        cnt = 0;
        do begin one_period(2'b01); cnt++; end while (!test && cnt < 20);
        check(cnt == 5, "R4 first pulse", cnt, 5);
        m = 9'd2;
        cnt = 0;
        do begin one_period(2'b01); cnt++; end while (!test && cnt < 20);
        check(cnt == 5, "R4 old count completes", cnt, 5);
        cnt = 0;
        do begin one_period(2'b01); cnt++; end while (!test && cnt < 20);
        check(cnt == 2, "R4 new count", cnt, 2);

        report();
        $finish;
    end

endmodule